// File: doc/BRIEF.md
# Pulse-Referenced Sample Window Capture

This block serves one receive channel of an ultrasonic pulser/receiver. When the channel's firing strobe arrives, it counts a programmable number of A/D clock cycles. This skips the part of the echo train that is of no interest, such as the wedge or water path. It then records a programmable number of 8-bit A/D samples, one per clock. It joins the samples two at a time into 16-bit words and pushes each word out on a write port that addresses DSP memory directly. The first word goes to a programmable base address, and each later word goes to the next address.

The whole block runs in the A/D clock domain. There is no stall path: the converter keeps producing samples, so the write port carries a one-cycle valid per word. A word the memory side does not take is lost, and the block records that loss in a sticky flag. Capture happens only while the run-mode input is high. When that input is low, the host owns the DSP port and the block stays idle.

Top module: `sample_window_capture`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `done` and `overrun` are all low.
- R2: Take the edge at which `fire` is accepted as edge E and `start_delay` as D. The first sample is the value of `adc_data` at edge E+D+1. Sample n is taken at edge E+D+1+n. Word k is presented (`wr_valid` high) in the cycle after edge E+D+2k+2.
- R3: Each word carries the earlier sample of its pair in bits 7:0 and the later sample in bits 15:8.
- R4: Word k is written to address `base_addr`+k, modulo 2^AW.
- R5: Exactly floor(`sample_count`/2) words are written. An odd count drops its final sample.
- R6: A count below 2 writes no word. `done` still pulses, in the cycle right after the accepting edge.
- R7: `done` is high for exactly one cycle, in the cycle after the last word's `wr_valid`.
- R8: A `fire` seen while a capture is active is ignored. The word stream and the `done` timing of the active capture are unchanged.
- R9: `fire` is ignored while `run_en` is low. If `run_en` drops during a capture, the capture is abandoned: no further word is written and `done` does not pulse.
- R10: `wr_valid` never stays high for two cycles in a row. A word presented while `wr_ready` is low sets `overrun`. `overrun` stays high until the next accepted `fire` clears it.
- R11: `busy` rises only after an accepted `fire`. It stays high until the edge that presents the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | A/D conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run mode; when low the block releases the DSP port |
| fire | input | 1 | Channel firing strobe |
| start_delay | input | CW | Clocks from firing to first sample |
| sample_count | input | CW | Samples to record (rounded down to even) |
| base_addr | input | AW | DSP memory address of the first word |
| adc_data | input | SW | A/D sample |
| wr_ready | input | 1 | Memory side takes the presented word |
| wr_valid | output | 1 | One-cycle word strobe |
| wr_addr | output | AW | Word address |
| wr_data | output | 2*SW | Packed sample pair |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle end-of-capture strobe |
| overrun | output | 1 | Sticky lost-word flag |

## Verification
The bench builds the block with CW=10 and AW=8, and keeps SW=8. With CW=10 the largest delay (1023) and the largest odd count (1023) both run in a few thousand cycles. This tests the counters at full scale and not just with small values. With AW=8 the address wraps from 0xFF to 0x00 within a three-word block, so the modulo rule of the address counter is tested. The A/D input follows a counter-derived pattern, so every word's value pins down exactly which cycles its two samples came from.

// File: rtl/sample_window_capture.sv
module sample_window_capture #(
  parameter int SW = 8,
  parameter int CW = 24,
  parameter int AW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            fire,
  input  logic [CW-1:0]   start_delay,
  input  logic [CW-1:0]   sample_count,
  input  logic [AW-1:0]   base_addr,
  input  logic [SW-1:0]   adc_data,
  input  logic            wr_ready,
  output logic            wr_valid,
  output logic [AW-1:0]   wr_addr,
  output logic [2*SW-1:0] wr_data,
  output logic            busy,
  output logic            done,
  output logic            overrun
);

  localparam int PW = CW - 1;

  typedef enum logic [1:0] {IDLE, WAIT, TAKE} st_t;

  st_t          st;
  logic [CW-1:0] dcnt;
  logic [PW-1:0] pairs;
  logic          half;
  logic [SW-1:0] lo;
  logic [AW-1:0] addr;
  logic          last_q;

  wire [PW-1:0] req_pairs = sample_count[CW-1:1];

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      dcnt     <= '0;
      pairs    <= '0;
      half     <= 1'b0;
      lo       <= '0;
      addr     <= '0;
      last_q   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      last_q   <= 1'b0;
      done     <= last_q;
      if (!run_en) begin
        st     <= IDLE;
        half   <= 1'b0;
        last_q <= 1'b0;
        done   <= 1'b0;
      end else begin
        case (st)
          IDLE: if (fire) begin
            overrun <= 1'b0;
            addr    <= base_addr;
            dcnt    <= start_delay;
            pairs   <= req_pairs;
            half    <= 1'b0;
            if (req_pairs == '0) done <= 1'b1;
            else                 st   <= WAIT;
          end
          WAIT: begin
            if (dcnt == '0) begin
              lo   <= adc_data;
              half <= 1'b1;
              st   <= TAKE;
            end else begin
              dcnt <= dcnt - 1'b1;
            end
          end
          TAKE: begin
            if (!half) begin
              lo   <= adc_data;
              half <= 1'b1;
            end else begin
              wr_valid <= 1'b1;
              wr_data  <= {adc_data, lo};
              wr_addr  <= addr;
              addr     <= addr + 1'b1;
              half     <= 1'b0;
              pairs    <= pairs - 1'b1;
              if (pairs == PW'(1)) begin
                st     <= IDLE;
                last_q <= 1'b1;
              end
            end
          end
          default: st <= IDLE;
        endcase
      end
      if (wr_valid && !wr_ready) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/swc_chk.sv
module swc_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic fire,
  input logic wr_valid,
  input logic wr_ready,
  input logic busy,
  input logic done,
  input logic overrun
);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overrun);

  // R10
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fire) |=> overrun);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!busy && !wr_valid && !done));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fire && run_en));

endmodule

bind sample_window_capture swc_chk u_swc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .fire     (fire),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .busy     (busy),
  .done     (done),
  .overrun  (overrun)
);

// File: tb/tb_sample_window_capture.sv
module tb_sample_window_capture;

  localparam int SW = 8;
  localparam int CW = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic fire = 1'b0;
  logic [CW-1:0] start_delay = '0;
  logic [CW-1:0] sample_count = '0;
  logic [AW-1:0] base_addr = '0;
  logic [SW-1:0] adc_data = '0;
  logic wr_ready = 1'b1;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [2*SW-1:0] wr_data;
  logic busy, done, overrun;

  sample_window_capture #(.SW(SW), .CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fire(fire),
    .start_delay(start_delay), .sample_count(sample_count),
    .base_addr(base_addr), .adc_data(adc_data), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .overrun(overrun)
  );

  always #10 clk = ~clk;

  int ecount = 0;
  always @(posedge clk) ecount <= ecount + 1;

  function automatic logic [7:0] smp(int n);
    return 8'(n * 7 + 3);
  endfunction

  always @(negedge clk) adc_data <= smp(ecount);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  bit mon_on = 0;
  int exp_e0, exp_d, exp_base;
  int wcount, done_cnt, done_at;
  int raw_valid = 0, raw_done = 0;

  always @(negedge clk) begin
    if (wr_valid) raw_valid++;
    if (done) raw_done++;
    if (mon_on) begin
      if (wr_valid) begin
        chk("R2", "word cycle", ecount, exp_e0 + exp_d + 2*wcount + 2);
        chk("R4", "word address", wr_addr, (exp_base + wcount) % 256);
        chk("R3", "word data", wr_data,
            {smp(exp_e0 + exp_d + 2*wcount + 1), smp(exp_e0 + exp_d + 2*wcount)});
        wcount++;
      end
      if (done) begin
        done_cnt++;
        done_at = ecount;
      end
    end
  end

  task automatic run_cap(int d, int c, int b, bit rdy, bit refire);
    int p;
    p = c / 2;
    @(negedge clk);
    start_delay = CW'(d); sample_count = CW'(c); base_addr = AW'(b);
    wr_ready = rdy; fire = 1'b1;
    exp_e0 = ecount + 1; exp_d = d; exp_base = b;
    wcount = 0; done_cnt = 0; done_at = -1; mon_on = 1;
    @(negedge clk);
    fire = 1'b0;
    if (refire) begin
      repeat (2) @(negedge clk);
      start_delay = '0; base_addr = 8'hAA;
      fire = 1'b1;
      @(negedge clk);
      fire = 1'b0;
    end
    while (ecount < exp_e0 + d + 2*p + 3) @(negedge clk);
    mon_on = 0;
    chk("R5", "word count", wcount, p);
    chk("R7", "done pulses", done_cnt, 1);
    if (p == 0) chk("R6", "done cycle", done_at, exp_e0);
    else        chk("R7", "done cycle", done_at, exp_e0 + d + 2*p + 1);
    chk("R10", "overrun", overrun, (!rdy && p > 0));
    chk("R11", "busy after", busy, 0);
    if (refire) chk("R8", "refire ignored words", wcount, p);
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // {delay, count, base, ready, refire}
  localparam logic [29:0] VEC [10] = '{
    {10'd0,    10'd2,    8'h10, 1'b1, 1'b0},
    {10'd3,    10'd8,    8'h20, 1'b1, 1'b0},
    {10'd5,    10'd7,    8'h30, 1'b1, 1'b0},
    {10'd0,    10'd0,    8'h40, 1'b1, 1'b0},
    {10'd1,    10'd1,    8'h50, 1'b1, 1'b0},
    {10'd4,    10'd6,    8'hFE, 1'b1, 1'b0},
    {10'd2,    10'd10,   8'h60, 1'b1, 1'b1},
    {10'd1,    10'd4,    8'h70, 1'b0, 1'b0},
    {10'd0,    10'd4,    8'h80, 1'b1, 1'b0},
    {10'd1023, 10'd1023, 8'h05, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int v0, d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "wr_valid", wr_valid, 0);
    chk("R1", "done", done, 0);
    chk("R1", "overrun", overrun, 0);

    // R9: fire ignored with run mode off
    sample_count = 10'd4; start_delay = '0;
    v0 = raw_valid; d0 = raw_done;
    fire = 1'b1; @(negedge clk); fire = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9", "busy with run off", busy, 0);
    chk("R9", "writes with run off", raw_valid - v0, 0);
    chk("R9", "done with run off", raw_done - d0, 0);

    run_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      run_cap(int'(VEC[i][29:20]), int'(VEC[i][19:10]), int'(VEC[i][9:2]),
              VEC[i][1], VEC[i][0]);
    end

    // R9: abort by dropping run mode mid-capture
    start_delay = 10'd2; sample_count = 10'd20; base_addr = 8'h90;
    fire = 1'b1; @(negedge clk); fire = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11", "busy mid capture", busy, 1);
    run_en = 1'b0;
    @(negedge clk);
    v0 = raw_valid; d0 = raw_done;
    chk("R9", "busy after abort", busy, 0);
    repeat (30) @(negedge clk);
    chk("R9", "writes after abort", raw_valid - v0, 0);
    chk("R9", "done after abort", raw_done - d0, 0);
    run_en = 1'b1;
    @(negedge clk);
    run_cap(1, 4, 8'h33, 1'b1, 1'b0);

    finished = 1;
    summary();
    $finish;
  end

endmodule